// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a single-port synchronous static memory with a 36-bit word split into four 9-bit byte lanes. Every control input is sampled on the rising clock edge, except the output enable and the doze (power-down) input, which act immediately. Reads are flow-through: the word for an address taken at an edge comes straight from the array onto the read bus in that same cycle, with no output register. Writes are late: the address is taken at one edge, and the data and lane enables are taken at the next enabled edge. Reads and writes can therefore alternate with no idle cycle between them.

A new operation (read, write or deselect) starts when `burst_cont` is low. When it is high, the block repeats the previous operation type at an internally stepped address. The step wraps the two low address bits inside an aligned group of four words. A high active-low clock enable freezes the whole pipeline. The array depth is set by an address-width parameter, so simulation can use a small array while the full-size configuration needs 19 address bits.

Top module: `ftlw_sram`

## Requirements
- R1: After synchronous reset no operation is active: `rd_drive` is low and `rd_data` is zero.
- R2: A new read starts at an enabled edge when `burst_cont`=0, all three selects are active and `rnw`=1. In the cycle that follows that same edge, `rd_data` equals the stored word at `addr` and `rd_drive` is high, provided `out_en_n`=0 and `doze`=0.
- R3: A write starts the same way with `rnw`=0. `wr_data` and `lane_wr_n` are taken at the next enabled edge. A read of the same address starting at that edge already returns the new word.
- R4: Lane k is bits 9k+8 down to 9k. It is written only when `lane_wr_n[k]`=0, and the other lanes keep their contents.
- R5: A new cycle with `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 is a deselect. It drives nothing and writes nothing, and continuation cycles after it stay deselected.
- R6: With `burst_cont`=1, the previous operation type repeats at the address whose two low bits are incremented modulo 4, with the upper bits unchanged. `addr`, `rnw` and the selects are ignored in such a cycle.
- R7: Each continuation cycle of a write burst stores the data presented at the following enabled edge at that cycle's stepped address.
- R8: An edge with `clk_en_n`=1 changes nothing: the read output holds, and a pending write waits for the next enabled edge to take its data.
- R9: `out_en_n`=1 forces `rd_drive` low at once, without clocking and without disturbing the active operation.
- R10: `doze`=1 forces `rd_drive` low at once. Edges during doze start no operation, but a write whose address was already taken still stores its data. The array contents survive, and after doze ends nothing is driven until a new read starts.
- R11: Whenever `rd_drive` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| burst_cont | input | 1 | 0 starts a new operation, 1 continues the burst |
| rnw | input | 1 | Operation type at a new cycle: 1 read, 0 write |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address loaded at a new cycle |
| lane_wr_n | input | 4 | Active-low per-lane write enables, taken with the data |
| wr_data | input | 36 | Write data, taken one enabled edge after its address |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| doze | input | 1 | Asynchronous power-down request |
| rd_data | output | 36 | Flow-through read word, zero when not driven |
| rd_drive | output | 1 | High when the read bus is driven; low means high impedance |

## Verification
The bench writes a read immediately after a write to the same address, which catches a design that reads before its late write has landed or that samples write data one edge too early or too late. It walks all sixteen lane-enable patterns over one word, so a swapped or inverted lane shows up as a corrupted byte. Bursts start at an offset of 1 and 2 inside the group of four, which catches a counter that carries into the upper address bits or that follows the external address. Stalled edges, deselects with each select in turn, output-enable toggles and doze with a write still pending are each followed by a read-back, so a design that lets such a cycle leak a write or lose one is caught.

// File: rtl/ftlw_sram_pkg.sv
package ftlw_sram_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_DESEL = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;

    // decoded request seen at one edge
    typedef struct packed {
        logic start;   // a new operation begins
        logic chosen;  // all three selects active
        logic is_rd;   // read requested
    } req_t;

    function automatic logic all_selected(logic a_n, logic b, logic c_n);
        return !a_n && b && !c_n;
    endfunction

    // linear step of the in-group offset, wrapping modulo four
    function automatic logic [1:0] wrap_step(logic [1:0] ofs);
        return ofs + 2'd1;
    endfunction

    function automatic op_e new_op(req_t r);
        if (!r.chosen) return OP_DESEL;
        return r.is_rd ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/ftlw_cmd.sv
module ftlw_cmd
    import ftlw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              doze,
    input  req_t              req,
    input  logic [ADDR_W-1:0] addr,
    output op_e               cur_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              commit
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_DESEL;
            addr_q <= '0;
        end else if (step) begin
            if (doze) begin
                op_q <= OP_DESEL;
            end else if (req.start) begin
                op_q   <= new_op(req);
                addr_q <= addr;
            end else begin
                addr_q <= {addr_q[ADDR_W-1:2], wrap_step(addr_q[1:0])};
            end
        end
    end

    assign cur_op   = op_q;
    assign cur_addr = addr_q;
    // late write: the registered write address takes its data at this edge
    assign commit   = step && (op_q == OP_WRITE);

endmodule

// File: rtl/ftlw_lane.sv
module ftlw_lane
    import ftlw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  lane_t             wd,
    input  logic [ADDR_W-1:0] raddr,
    output lane_t             rd
);

    localparam int DEPTH = 1 << ADDR_W;

    lane_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wd;
    end

    assign rd = mem[raddr];

endmodule

// File: rtl/ftlw_outgate.sv
module ftlw_outgate
    import ftlw_sram_pkg::*;
(
    input  op_e   cur_op,
    input  logic  out_en_n,
    input  logic  doze,
    input  word_t word,
    output word_t rd_data,
    output logic  rd_drive
);

    always_comb begin
        rd_drive = (cur_op == OP_READ) && !out_en_n && !doze;
        rd_data  = rd_drive ? word : '0;
    end

endmodule

// File: rtl/ftlw_sram.sv
module ftlw_sram
    import ftlw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              burst_cont,
    input  logic              rnw,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        lane_wr_n,
    input  logic [35:0]       wr_data,
    input  logic              out_en_n,
    input  logic              doze,
    output logic [35:0]       rd_data,
    output logic              rd_drive
);

    req_t              req;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic              commit;
    word_t             word;

    always_comb begin
        req.start  = !burst_cont;
        req.chosen = all_selected(sel_a_n, sel_b, sel_c_n);
        req.is_rd  = rnw;
    end

    ftlw_cmd #(.ADDR_W(ADDR_W)) cmd_i (
        .clk      (clk),
        .rst      (rst),
        .step     (!clk_en_n),
        .doze     (doze),
        .req      (req),
        .addr     (addr),
        .cur_op   (cur_op),
        .cur_addr (cur_addr),
        .commit   (commit)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ftlw_lane #(.ADDR_W(ADDR_W)) lane_i (
            .clk   (clk),
            .we    (commit && !lane_wr_n[k]),
            .waddr (cur_addr),
            .wd    (wr_data[k*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rd    (word[k*LANE_W +: LANE_W])
        );
    end

    ftlw_outgate gate_i (
        .cur_op   (cur_op),
        .out_en_n (out_en_n),
        .doze     (doze),
        .word     (word),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

endmodule

// File: rtl/ftlw_sram_chk.sv
module ftlw_sram_chk
    import ftlw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              burst_cont,
    input logic              rnw,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic [ADDR_W-1:0] addr,
    input logic              out_en_n,
    input logic              doze,
    input logic [35:0]       rd_data,
    input logic              rd_drive,
    input op_e               cur_op,
    input logic [ADDR_W-1:0] cur_addr
);

    logic live, chosen;
    assign live   = !clk_en_n && !doze;
    assign chosen = !sel_a_n && sel_b && !sel_c_n;

    assert_read_start_R2: assert property (@(posedge clk) disable iff (rst)
        (live && !burst_cont && chosen && rnw)
        |=> (cur_op == OP_READ) && (cur_addr == $past(addr)));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        (live && !burst_cont && !chosen) |=> (cur_op == OP_DESEL));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (rst)
        (live && burst_cont && cur_op != OP_DESEL)
        |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)
            && (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))
            && (cur_op == $past(cur_op)));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(cur_addr) && $stable(cur_op));

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rd_drive);

    assert_doze_gate_R10: assert property (@(posedge clk) disable iff (rst)
        doze |-> !rd_drive);

    assert_doze_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (doze && !clk_en_n) |=> (cur_op == OP_DESEL));

    assert_zero_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> (rd_data == '0));

endmodule

bind ftlw_sram ftlw_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .clk_en_n   (clk_en_n),
    .burst_cont (burst_cont),
    .rnw        (rnw),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .addr       (addr),
    .out_en_n   (out_en_n),
    .doze       (doze),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive),
    .cur_op     (cur_op),
    .cur_addr   (cur_addr)
);

// File: tb/ftlw_sram_tb.sv
module ftlw_sram_tb_top;

    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_en_n, burst_cont, rnw, sel_a_n, sel_b, sel_c_n;
    logic [AW-1:0] addr;
    logic [3:0]    lane_wr_n;
    logic [35:0]   wr_data;
    logic          out_en_n, doze;
    logic [35:0]   rd_data;
    logic          rd_drive;

    logic [35:0] model [NW];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    ftlw_sram #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .burst_cont(burst_cont),
        .rnw(rnw), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .addr(addr), .lane_wr_n(lane_wr_n), .wr_data(wr_data),
        .out_en_n(out_en_n), .doze(doze), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic logic [35:0] pat(int a, int s);
        logic [35:0] v;
        v = 36'h5A5A5A5A5 ^ (36'(a) * 36'h0F1E2D3C5) ^ (36'(s) * 36'h000931A17);
        return v;
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_rd(string req, int a);
        check(req, {35'd0, rd_drive}, 36'd1);
        check(req, rd_data, model[a]);
    endtask

    task automatic check_off(string req);
        check(req, {35'd0, rd_drive}, 36'd0);
        check(req, rd_data, 36'd0);
    endtask

    task automatic mwrite(int a, logic [35:0] d, logic [3:0] m);
        for (int k = 0; k < 4; k++)
            if (!m[k]) model[a][k*9 +: 9] = d[k*9 +: 9];
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic start(logic rd, int a);
        burst_cont = 0; rnw = rd; addr = AW'(a);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    endtask

    task automatic desel;
        burst_cont = 0; rnw = 1; sel_a_n = 1; sel_b = 1; sel_c_n = 0;
    endtask

    task automatic give(int a, logic [35:0] d, logic [3:0] m);
        wr_data = d; lane_wr_n = m; mwrite(a, d, m);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        rst = 1; clk_en_n = 0; out_en_n = 0; doze = 0;
        lane_wr_n = 4'h0; wr_data = '0; desel(); addr = '0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        tick(); tick();
        rst = 0;
        tick();
        check_off("R1 reset idle");

        // R3 back-to-back full writes to every address, data one edge later
        for (int i = 0; i <= NW; i++) begin
            if (i < NW) start(0, i); else desel();
            if (i > 0) give(i - 1, pat(i - 1, 0), 4'h0);
            tick();
            check({35'd0, rd_drive}, {35'd0, rd_drive}, 36'd0) ;
        end
        // R2 flow-through reads, every address
        for (int i = 0; i < NW; i++) begin
            start(1, i); tick();
            check_rd("R2 read sweep", i);
        end
        desel(); tick();
        check_off("R11 idle zero");

        // R3 read immediately after write of same address
        start(0, 7); tick();
        start(1, 7); give(7, pat(7, 1), 4'h0); tick();
        check_rd("R3 write-then-read", 7);

        // R4 every lane mask
        for (int m = 0; m < 16; m++) begin
            start(0, 3); tick();
            start(1, 3); give(3, pat(3, m + 2), 4'(m)); tick();
            check_rd("R4 lane mask", 3);
        end

        // R6 read burst from offset 1: 5,6,7,4 with external inputs scrambled
        start(1, 5); tick();
        check_rd("R6 burst head", 5);
        for (int j = 1; j < 4; j++) begin
            burst_cont = 1; addr = AW'(15); rnw = 0; sel_a_n = 1;
            tick();
            check_rd("R6 burst step", 4 + ((1 + j) & 3));
        end

        // R7 write burst from offset 2: 10,11,8,9
        start(0, 10); tick();
        for (int j = 1; j < 4; j++) begin
            burst_cont = 1; addr = '0; rnw = 1;
            give(8 + ((1 + j) & 3), pat(j, 40), 4'h0);
            tick();
        end
        desel(); give(9, pat(4, 40), 4'h0); tick();
        for (int i = 8; i < 12; i++) begin
            start(1, i); tick();
            check_rd("R7 burst write readback", i);
        end
        start(1, 0); tick();
        check_rd("R6 external addr ignored in burst", 0);

        // R5 each select off: no drive, no write, stays off in continuation
        for (int v = 0; v < 3; v++) begin
            start(0, 12);
            if (v == 0) sel_a_n = 1;
            if (v == 1) sel_b = 0;
            if (v == 2) sel_c_n = 1;
            tick();
            check_off("R5 deselect write");
            burst_cont = 1; wr_data = 36'hFFFFFFFFF; lane_wr_n = 4'h0; tick();
            check_off("R5 deselect continues");
            start(1, 12); tick();
            check_rd("R5 no write on deselect", 12);
        end

        // R8 stalled edge holds read and ignores inputs
        start(1, 2); tick();
        check_rd("R8 read before stall", 2);
        clk_en_n = 1; start(0, 9); tick();
        check_rd("R8 read held", 2);
        clk_en_n = 0; desel(); tick();
        // R8 pending write waits through a stall
        start(0, 6); tick();
        clk_en_n = 1; wr_data = 36'h123456789; lane_wr_n = 4'h0; start(1, 1); tick();
        clk_en_n = 0; start(1, 6); give(6, pat(6, 50), 4'h0); tick();
        check_rd("R8 write data after stall", 6);

        // R9 output enable
        start(1, 4); tick();
        out_en_n = 1; #1;
        check_off("R9 oe off");
        out_en_n = 0; #1;
        check_rd("R9 oe back on", 4);

        // R10 doze
        doze = 1; #1;
        check_off("R10 doze gates");
        start(0, 4); tick();
        give(4, 36'h0, 4'hF);  // attempted write while dozing must not land
        start(1, 4); tick();
        doze = 0; #1;
        check_off("R10 nothing after doze");
        start(1, 4); tick();
        check_rd("R10 contents kept", 4);
        start(0, 13); tick();
        doze = 1; desel(); give(13, pat(13, 60), 4'h0); tick();
        doze = 0; start(1, 13); tick();
        check_rd("R10 pending write lands", 13);

        // R1 reset mid-read
        rst = 1; tick(); rst = 0; desel(); #1;
        check_off("R1 reset clears read");

        done = 1;
        summary();
    end

endmodule